// File: doc/BRIEF.md
# Write-Back Data Cache with Word-Granular Dirty Tracking

This block is a direct-mapped data cache. It sits between a processor word port and a main-memory port that moves one 32-bit word per beat. A store that hits changes only the cache. A store that misses first fetches the whole line and then merges the store into it. Main memory is written only when a line holding modified words is displaced. Each word has its own modified flag, so only the modified words of the victim go back to memory.

A second, coherence port serves an I/O agent. A purge command flushes the modified words of the addressed line to memory and keeps the line resident and clean. This is used before a device reads that memory. An invalidate command drops the addressed line after a device has overwritten its memory, so that stale data cannot be returned. All addresses are 32-bit word addresses. A processor address splits into tag (upper bits), line index (next `$clog2(LINES)` bits) and word-in-line (lowest `$clog2(WORDS)` bits). The coherence port takes a line address, which is the tag and the index only.

Top module: `wbw_cache`

## Requirements
- R1: A store that hits raises `cpu_ready_o` in the cycle of the request, updates the cache, and issues no memory read or write.
- R2: A load that hits raises `cpu_ready_o` in the cycle of the request, with the addressed word on `cpu_rdata_o`.
- R3: A load or store miss issues one single-cycle `mem_rd_req_o` whose address is the line base (word bits zero). It then takes four beats on `mem_rd_valid_i` into words 0 to 3 in order, and serves the request from the refilled line. A store miss merges into the fetched words.
- R4: Memory is written only while a line with modified words is being displaced or purged. Exactly the modified words are written, one per cycle, lowest word first, each at its own word address `{tag, index, word}`.
- R5: Bit i of `cpu_be_i` selects byte lane i (bits 8i+7..8i) of the stored word. Lanes not selected keep their value. Any store sets the modified flag of that word.
- R6: A refill leaves every word of the line unmodified, so a later displacement of that line writes nothing unless it is stored to again.
- R7: `cpu_ready_o` stays low during write-back and refill. With memory returning the first beat 5 cycles after the request cycle, a clean miss completes 9 cycles after the request's first cycle, plus one cycle per modified word written back.
- R8: `io_cmd_i` = 2'b01 (invalidate) on a resident line clears it, so the next access refetches from memory. On a line that is not resident it changes nothing. `io_ready_o` marks completion.
- R9: `io_cmd_i` = 2'b10 (purge) on a resident line writes its modified words to memory and clears their flags. The line stays resident. A purge of a clean line writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 14 | Processor word address |
| cpu_be_i | input | 4 | Store byte-lane enables |
| cpu_wdata_i | input | 32 | Store data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | 32 | Load data, valid with ready |
| mem_rd_req_o | output | 1 | Line fetch request pulse |
| mem_rd_addr_o | output | 14 | Line base word address of the fetch |
| mem_rd_valid_i | input | 1 | Fetch beat valid |
| mem_rd_data_i | input | 32 | Fetch beat data |
| mem_wr_valid_o | output | 1 | Memory word write this cycle |
| mem_wr_addr_o | output | 14 | Word address of the write |
| mem_wr_data_o | output | 32 | Data of the write |
| io_cmd_i | input | 2 | 00 none, 01 invalidate, 10 purge, held until ready |
| io_addr_i | input | 12 | Line address of the coherence command |
| io_ready_o | output | 1 | Coherence command completes this cycle |

## Verification
Hits are due in the request's own cycle. The bench drives at the falling edge and reads ready and data one time step later, in that same cycle. Misses are timed by counting falling edges until ready. The count must be 9 for a clean line and 9 plus the number of modified words for a dirty one, against a memory model that holds the first beat back 5 cycles. Memory traffic is logged at each falling edge, and every access is checked for the exact number of fetches and word writes it caused and, for flushes, their addresses and data.

// File: rtl/wbw_pkg.sv
package wbw_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_WB,
    S_REQ,
    S_FILL
  } wbw_state_e;

  localparam logic [1:0] IO_INV   = 2'b01;
  localparam logic [1:0] IO_PURGE = 2'b10;
endpackage

// File: rtl/wbw_pick.sv
// lowest set bit of the dirty mask, and whether it is the only one
module wbw_pick #(
  parameter int WORDS  = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic [WORDS-1:0]  mask_i,
  output logic [WORD_W-1:0] idx_o,
  output logic              last_o
);
  logic [WORDS-1:0] rest;

  always_comb begin
    idx_o = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = i[WORD_W-1:0];
    end
    rest = mask_i;
    rest[idx_o] = 1'b0;
    last_o = (rest == '0);
  end
endmodule

// File: rtl/wbw_store.sv
module wbw_store #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 9,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [WORD_W-1:0]             word_i,
  input  logic                          wr_en_i,
  input  logic [BE_W-1:0]               be_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          fill_en_i,
  input  logic [DATA_W-1:0]             fill_data_i,
  input  logic                          fill_done_i,
  input  logic [TAG_W-1:0]              tag_i,
  input  logic                          inval_i,
  input  logic                          dclr_i,
  output logic                          valid_o,
  output logic [TAG_W-1:0]              tag_o,
  output logic [WORDS-1:0]              dirty_o,
  output logic [WORDS-1:0][DATA_W-1:0]  line_o
);
  logic [LINES-1:0]                         valid_q;
  logic [LINES-1:0][WORDS-1:0]              dirty_q;
  logic [LINES-1:0][TAG_W-1:0]              tag_q;
  logic [LINES-1:0][WORDS-1:0][DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]                        cur_word;
  logic [DATA_W-1:0]                        merged;

  assign cur_word = data_q[idx_i][word_i];

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged[8*b +: 8] = be_i[b] ? wdata_i[8*b +: 8] : cur_word[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inval_i) begin
        valid_q[idx_i] <= 1'b0;
        dirty_q[idx_i] <= '0;
      end
      if (wr_en_i) dirty_q[idx_i][word_i] <= 1'b1;
      if (dclr_i)  dirty_q[idx_i][word_i] <= 1'b0;
      if (fill_done_i) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i)     data_q[idx_i][word_i] <= merged;
    if (fill_en_i)   data_q[idx_i][word_i] <= fill_data_i;
    if (fill_done_i) tag_q[idx_i] <= tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign line_o  = data_q[idx_i];

  p_dirty_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> dirty_q[$past(idx_i)][$past(word_i)]);

  p_refill_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_i |=> (dirty_q[$past(idx_i)] == '0) && valid_q[$past(idx_i)]);

  p_inval_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !valid_q[$past(idx_i)]);
endmodule

// File: rtl/wbw_ctrl.sv
module wbw_ctrl
  import wbw_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int TAG_W = 9,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic [WORD_W-1:0] cpu_word_i,
  input  logic [1:0]        io_cmd_i,
  input  logic [IDX_W-1:0]  io_idx_i,
  input  logic [TAG_W-1:0]  io_tag_i,
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [WORDS-1:0]  dirty_i,
  input  logic [WORD_W-1:0] pick_word_i,
  input  logic              pick_last_i,
  input  logic              mem_rd_valid_i,
  output logic              cpu_ready_o,
  output logic              io_ready_o,
  output logic [IDX_W-1:0]  line_idx_o,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_en_o,
  output logic              fill_en_o,
  output logic              fill_done_o,
  output logic              inval_o,
  output logic              dclr_o,
  output logic              mem_rd_req_o,
  output logic              mem_wr_valid_o
);
  wbw_state_e        state_q, state_d;
  logic [IDX_W-1:0]  wb_idx_q, wb_idx_d;
  logic              purge_q, purge_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic              io_act, io_hit, cpu_hit;

  assign io_act  = (io_cmd_i == IO_INV) || (io_cmd_i == IO_PURGE);
  assign io_hit  = valid_i && (tag_i == io_tag_i);
  assign cpu_hit = valid_i && (tag_i == cpu_tag_i);

  always_comb begin
    state_d        = state_q;
    wb_idx_d       = wb_idx_q;
    purge_d        = purge_q;
    beat_d         = beat_q;
    cpu_ready_o    = 1'b0;
    io_ready_o     = 1'b0;
    line_idx_o     = cpu_idx_i;
    word_o         = cpu_word_i;
    wr_en_o        = 1'b0;
    fill_en_o      = 1'b0;
    fill_done_o    = 1'b0;
    inval_o        = 1'b0;
    dclr_o         = 1'b0;
    mem_rd_req_o   = 1'b0;
    mem_wr_valid_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (io_act) begin
          line_idx_o = io_idx_i;
          if (!io_hit) begin
            io_ready_o = 1'b1;
          end else if (io_cmd_i == IO_INV) begin
            inval_o    = 1'b1;
            io_ready_o = 1'b1;
          end else if (dirty_i != '0) begin
            state_d  = S_WB;
            wb_idx_d = io_idx_i;
            purge_d  = 1'b1;
          end else begin
            io_ready_o = 1'b1;
          end
        end else if (cpu_req_i) begin
          if (cpu_hit) begin
            cpu_ready_o = 1'b1;
            wr_en_o     = cpu_we_i;
          end else if (valid_i && (dirty_i != '0)) begin
            state_d  = S_WB;
            wb_idx_d = cpu_idx_i;
            purge_d  = 1'b0;
          end else begin
            state_d = S_REQ;
          end
        end
      end
      S_WB: begin
        line_idx_o     = wb_idx_q;
        word_o         = pick_word_i;
        mem_wr_valid_o = 1'b1;
        dclr_o         = 1'b1;
        if (pick_last_i) state_d = purge_q ? S_IDLE : S_REQ;
      end
      S_REQ: begin
        mem_rd_req_o = 1'b1;
        beat_d       = '0;
        state_d      = S_FILL;
      end
      S_FILL: begin
        word_o = beat_q;
        if (mem_rd_valid_i) begin
          fill_en_o = 1'b1;
          beat_d    = beat_q + 1'b1;
          if (beat_q == WORD_W'(WORDS - 1)) begin
            fill_done_o = 1'b1;
            state_d     = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      wb_idx_q <= '0;
      purge_q  <= 1'b0;
      beat_q   <= '0;
    end else begin
      state_q  <= state_d;
      wb_idx_q <= wb_idx_d;
      purge_q  <= purge_d;
      beat_q   <= beat_d;
    end
  end

  p_wb_only_dirty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> (dirty_i != '0));

  p_fetch_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |=> !mem_rd_req_o);

  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |-> !cpu_ready_o && !io_ready_o);

  p_purge_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_ready_o && (io_cmd_i == IO_PURGE) && io_hit) |-> (dirty_i == '0));
endmodule

// File: rtl/wbw_cache.sv
module wbw_cache #(
  parameter int AW     = 14,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int TAG_W  = AW - IDX_W - WORD_W,
  localparam int LA_W   = AW - WORD_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_rd_req_o,
  output logic [AW-1:0]     mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_valid_o,
  output logic [AW-1:0]     mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic [1:0]        io_cmd_i,
  input  logic [LA_W-1:0]   io_addr_i,
  output logic              io_ready_o
);
  logic [TAG_W-1:0]              cpu_tag, io_tag, st_tag;
  logic [IDX_W-1:0]              cpu_idx, io_idx, line_idx;
  logic [WORD_W-1:0]             cpu_word, word_sel, pick_word;
  logic                          pick_last, st_valid;
  logic [WORDS-1:0]              st_dirty;
  logic [WORDS-1:0][DATA_W-1:0]  st_line;
  logic                          wr_en, fill_en, fill_done, inval, dclr;

  assign {cpu_tag, cpu_idx, cpu_word} = cpu_addr_i;
  assign {io_tag, io_idx}             = io_addr_i;

  wbw_store #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_i(line_idx), .word_i(word_sel),
    .wr_en_i(wr_en), .be_i(cpu_be_i), .wdata_i(cpu_wdata_i),
    .fill_en_i(fill_en), .fill_data_i(mem_rd_data_i),
    .fill_done_i(fill_done), .tag_i(cpu_tag),
    .inval_i(inval), .dclr_i(dclr),
    .valid_o(st_valid), .tag_o(st_tag), .dirty_o(st_dirty), .line_o(st_line)
  );

  wbw_pick #(.WORDS(WORDS)) u_pick (
    .mask_i(st_dirty), .idx_o(pick_word), .last_o(pick_last)
  );

  wbw_ctrl #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
    .cpu_idx_i(cpu_idx), .cpu_tag_i(cpu_tag), .cpu_word_i(cpu_word),
    .io_cmd_i(io_cmd_i), .io_idx_i(io_idx), .io_tag_i(io_tag),
    .valid_i(st_valid), .tag_i(st_tag), .dirty_i(st_dirty),
    .pick_word_i(pick_word), .pick_last_i(pick_last),
    .mem_rd_valid_i(mem_rd_valid_i),
    .cpu_ready_o(cpu_ready_o), .io_ready_o(io_ready_o),
    .line_idx_o(line_idx), .word_o(word_sel),
    .wr_en_o(wr_en), .fill_en_o(fill_en), .fill_done_o(fill_done),
    .inval_o(inval), .dclr_o(dclr),
    .mem_rd_req_o(mem_rd_req_o), .mem_wr_valid_o(mem_wr_valid_o)
  );

  assign cpu_rdata_o   = st_line[cpu_word];
  assign mem_rd_addr_o = {cpu_tag, cpu_idx, {WORD_W{1'b0}}};
  assign mem_wr_addr_o = {st_tag, line_idx, pick_word};
  assign mem_wr_data_o = st_line[pick_word];

  p_hit_no_mem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !mem_wr_valid_o && !mem_rd_req_o);
endmodule

// File: tb/sim_wbw_cache.sv
module sim_wbw_cache;
  localparam int LAT = 5;

  typedef struct packed {
    logic        we;
    logic [13:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [7:0]  lat;
    logic [3:0]  nwr;
    logic [3:0]  nrd;
  } vec_t;

  // addr = {tag[8:0], idx[2:0], word[1:0]}; unwritten memory reads D0000000|addr
  localparam vec_t VECS [13] = '{
    '{1'b0, 14'h004, 4'h0, 32'h0,        32'hD0000004, 8'd9,  4'd0, 4'd1}, // R3 R7 clean miss
    '{1'b0, 14'h005, 4'h0, 32'h0,        32'hD0000005, 8'd0,  4'd0, 4'd0}, // R2 hit
    '{1'b1, 14'h006, 4'hF, 32'h11111111, 32'h0,        8'd0,  4'd0, 4'd0}, // R1 store hit
    '{1'b0, 14'h006, 4'h0, 32'h0,        32'h11111111, 8'd0,  4'd0, 4'd0}, // R1
    '{1'b1, 14'h007, 4'h3, 32'hAAAABBBB, 32'h0,        8'd0,  4'd0, 4'd0}, // R5 lanes 0,1
    '{1'b0, 14'h007, 4'h0, 32'h0,        32'hD000BBBB, 8'd0,  4'd0, 4'd0}, // R5
    '{1'b0, 14'h024, 4'h0, 32'h0,        32'hD0000024, 8'd11, 4'd2, 4'd1}, // R4 R7 two dirty
    '{1'b0, 14'h006, 4'h0, 32'h0,        32'h11111111, 8'd9,  4'd0, 4'd1}, // R6 clean victim
    '{1'b0, 14'h007, 4'h0, 32'h0,        32'hD000BBBB, 8'd0,  4'd0, 4'd0}, // R4 data survived
    '{1'b1, 14'h048, 4'h8, 32'h5A000000, 32'h0,        8'd9,  4'd0, 4'd1}, // R3 store miss
    '{1'b0, 14'h048, 4'h0, 32'h0,        32'h5A000048, 8'd0,  4'd0, 4'd0}, // R3 merged
    '{1'b0, 14'h008, 4'h0, 32'h0,        32'hD0000008, 8'd10, 4'd1, 4'd1}, // R4 R7 one dirty
    '{1'b0, 14'h048, 4'h0, 32'h0,        32'h5A000048, 8'd9,  4'd0, 4'd1}  // R4 refetch
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [13:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        ready, rd_req, rd_valid = 1'b0, wr_valid, io_ready;
  logic [31:0] rdata, rd_data = '0, wr_data;
  logic [13:0] rd_addr, wr_addr;
  logic [1:0]  io_cmd = 2'b00;
  logic [11:0] io_addr = '0;

  int          n_total = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
  logic [31:0] mem [int];
  int          wlog_a [$];
  logic [31:0] wlog_d [$];

  always #4 clk = ~clk;

  wbw_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_be_i(be),
    .cpu_wdata_i(wdata), .cpu_ready_o(ready), .cpu_rdata_o(rdata),
    .mem_rd_req_o(rd_req), .mem_rd_addr_o(rd_addr),
    .mem_rd_valid_i(rd_valid), .mem_rd_data_i(rd_data),
    .mem_wr_valid_o(wr_valid), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .io_cmd_i(io_cmd), .io_addr_i(io_addr), .io_ready_o(io_ready)
  );

  function automatic logic [31:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : (32'hD0000000 | 32'(a));
  endfunction

  always @(negedge clk) begin
    if (wr_valid) begin
      mem[int'(wr_addr)] = wr_data;
      wlog_a.push_back(int'(wr_addr));
      wlog_d.push_back(wr_data);
      wr_cnt++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        automatic int base = int'(rd_addr);
        rd_cnt++;
        repeat (LAT - 1) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          rd_valid = 1'b1;
          rd_data  = mem_rd(base + b);
          @(negedge clk);
        end
        rd_valid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu(input logic w, input logic [13:0] a, input logic [3:0] b,
                     input logic [31:0] d, output logic [31:0] q, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    lat = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1;
      lat++;
    end
    q = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic io(input logic [1:0] c, input logic [11:0] la);
    @(negedge clk);
    io_cmd = c; io_addr = la;
    #1;
    while (!io_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    io_cmd = 2'b00;
  endtask

  task automatic access(input logic w, input logic [13:0] a, input logic [3:0] b,
                        input logic [31:0] d, input logic [31:0] exp_rd, input int exp_lat,
                        input int exp_wr, input int exp_rd_n, input string tag);
    logic [31:0] q;
    int lat, w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    cpu(w, a, b, d, q, lat);
    chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
    if (!w) chk(q == exp_rd, {tag, " rdata"}, q, exp_rd);
    chk(wr_cnt - w0 == exp_wr, {tag, " mem writes"}, 32'(wr_cnt - w0), 32'(exp_wr));
    chk(rd_cnt - r0 == exp_rd_n, {tag, " mem fetches"}, 32'(rd_cnt - r0), 32'(exp_rd_n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    #1;
    chk(!ready && !io_ready, "R7 reset ready low", {30'd0, ready, io_ready}, 32'd0);
    chk(!rd_req && !wr_valid, "R4 reset no memory traffic", {30'd0, rd_req, wr_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      access(VECS[i].we, VECS[i].addr, VECS[i].be, VECS[i].wdata, VECS[i].exp_rd,
             int'(VECS[i].lat), int'(VECS[i].nwr), int'(VECS[i].nrd),
             $sformatf("R1-vec%0d", i));
    end
    chk(mem_rd(6) == 32'h11111111, "R4 victim word2 in memory", mem_rd(6), 32'h11111111);
    chk(mem_rd(5) == 32'hD0000005, "R4 clean word1 not written", mem_rd(5), 32'hD0000005);

    // purge: line tag 4 idx 3
    access(1'b1, 14'h08D, 4'hF, 32'h12345678, '0, 9, 0, 1, "R3 store miss");
    access(1'b1, 14'h08F, 4'hF, 32'h9ABCDEF0, '0, 0, 0, 0, "R1 store hit");
    wlog_a.delete(); wlog_d.delete();
    w0 = wr_cnt;
    io(2'b10, 12'h023);
    chk(wr_cnt - w0 == 2, "R9 purge write count", 32'(wr_cnt - w0), 32'd2);
    if (wlog_a.size() == 2) begin
      chk(wlog_a[0] == 'h8D && wlog_d[0] == 32'h12345678, "R9 purge first word",
          wlog_d[0], 32'h12345678);
      chk(wlog_a[1] == 'h8F && wlog_d[1] == 32'h9ABCDEF0, "R9 purge second word",
          wlog_d[1], 32'h9ABCDEF0);
    end
    access(1'b0, 14'h08D, 4'h0, '0, 32'h12345678, 0, 0, 0, "R9 line stays resident");
    w0 = wr_cnt;
    io(2'b10, 12'h023);
    chk(wr_cnt - w0 == 0, "R9 purge of clean line", 32'(wr_cnt - w0), 32'd0);
    access(1'b0, 14'h00C, 4'h0, '0, 32'hD000000C, 9, 0, 1, "R9 purged line evicts silently");

    // invalidate: line tag 0 idx 4
    access(1'b0, 14'h010, 4'h0, '0, 32'hD0000010, 9, 0, 1, "R8 load line");
    mem[16] = 32'hCAFE0000;
    io(2'b01, 12'h044);
    access(1'b0, 14'h010, 4'h0, '0, 32'hD0000010, 0, 0, 0, "R8 other tag ignored");
    io(2'b01, 12'h004);
    access(1'b0, 14'h010, 4'h0, '0, 32'hCAFE0000, 9, 0, 1, "R8 refetch after invalidate");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule